// File: doc/BRIEF.md
# DRAM Command Legality Checker

This block watches a decoded DRAM command stream, one command per clock, and keeps a model of every bank: open or closed, and how many cycles have passed since that bank was last opened or closed. It catches corruption of the command and address bus by testing each command against that model. An activate that was never sent, one that arrived twice, or one that came too soon all break bank-state or timing legality. Refresh is checked against a deadline, because a lost refresh leaves no other trace.

Any illegal command, and any missed refresh deadline, produces a one-cycle error pulse with an error code and the bank involved. The block sits beside a controller or a device replica as a passive monitor. The command input has only a valid qualifier: the checker takes one command in every cycle and never applies back-pressure, so it has no ready signal. A command flagged as illegal does not change the model, which keeps reporting tied to the stream that was actually legal.

Opcodes on `cmd_op` are 0 no-op, 1 activate, 2 precharge, 3 read, 4 write and 5 refresh. Codes 6 and 7, and any cycle with `cmd_valid` low, are treated as no-ops. Error codes on `err_kind` are listed in the requirements.

Top module: `dram_cmd_checker`

## Requirements
- R1: After reset `err_valid` is 0, every bank is closed and the refresh timer is zero. Whenever `err_valid` is 0, `err_kind` is 0.
- R2: An activate to a bank that is already open reports code 1 with that bank.
- R3: An activate to a closed bank fewer than T_RP cycles after that bank's accepted precharge reports code 2. Exactly T_RP cycles later is legal.
- R4: A precharge to a closed bank reports code 3 with that bank.
- R5: A precharge to an open bank fewer than T_RAS cycles after its accepted activate reports code 4. Exactly T_RAS cycles later is legal.
- R6: A read or write to a closed bank reports code 5 with that bank.
- R7: A read or write to an open bank fewer than T_RCD cycles after its accepted activate reports code 6. Exactly T_RCD cycles later is legal.
- R8: If no refresh is accepted for REF_WINDOW clock edges, the block reports code 7 with bank 0, and reports it again after every further REF_WINDOW edges without a refresh. An accepted refresh restarts the count. Back-to-back refreshes are never an error.
- R9: A refresh while any bank is open reports code 8 with bank 0. That refresh is not accepted, so it does not restart the refresh count.
- R10: A command that is reported leaves the bank states and the timing counters unchanged. The report for a command appears on the outputs in the cycle after the command is presented.
- R11: If a command error and a refresh deadline fall on the same edge, the command error is reported first. The code-7 report follows on the next edge that has no command error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode (0 nop, 1 act, 2 pre, 3 rd, 4 wr, 5 ref) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| err_valid | output | 1 | One-cycle error pulse |
| err_kind | output | 4 | Error code (1..8) |
| err_bank | output | $clog2(NUM_BANKS) | Bank of the offending command, 0 for refresh errors |

## Verification
Two events can land on the same edge: a command that breaks bank legality, and the refresh deadline expiring. The bench provokes this by placing a precharge to a closed bank on exactly the edge where the refresh window runs out. It expects the precharge error in the first cycle and the overdue-refresh report in the next, with neither one lost. Separate sweeps move the gap between related commands across every timing boundary and compute the expected code from the gap and the parameter values.

// File: rtl/dram_cmd_pkg.sv
`timescale 1ns/1ps
package dram_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_PRE = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4,
    OP_REF = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    ERR_NONE        = 4'd0,
    ERR_EXTRA_ACT   = 4'd1,
    ERR_EARLY_ACT   = 4'd2,
    ERR_EXTRA_PRE   = 4'd3,
    ERR_EARLY_PRE   = 4'd4,
    ERR_MISSING_ACT = 4'd5,
    ERR_EARLY_RW    = 4'd6,
    ERR_REF_LATE    = 4'd7,
    ERR_REF_OPEN    = 4'd8
  } err_e;
endpackage

// File: rtl/delay_gate.sv
`timescale 1ns/1ps
// Down counter: after start, ready returns LEN cycles later.
module delay_gate #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int LOADV = (LEN > 0) ? LEN - 1 : 0;
  localparam int CW    = (LOADV > 0) ? $clog2(LOADV + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(LOADV);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/bank_track.sv
`timescale 1ns/1ps
// State and timing of a single bank.
module bank_track #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic pre_go,
  output logic is_open,
  output logic rcd_met,
  output logic ras_met,
  output logic rp_met
);
  always_ff @(posedge clk) begin
    if (!rst_n)      is_open <= 1'b0;
    else if (act_go) is_open <= 1'b1;
    else if (pre_go) is_open <= 1'b0;
  end

  delay_gate #(.LEN(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .start(act_go), .ready(rcd_met));
  delay_gate #(.LEN(T_RAS)) u_ras (.clk(clk), .rst_n(rst_n), .start(act_go), .ready(ras_met));
  delay_gate #(.LEN(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .start(pre_go), .ready(rp_met));
endmodule

// File: rtl/refresh_timer.sv
`timescale 1ns/1ps
// Raises due for one cycle each time WINDOW edges pass with no accepted refresh.
module refresh_timer #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok,
  output logic due
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt;

  assign due = (cnt == CW'(WINDOW - 1)) && !ref_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (ref_ok || due) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dram_cmd_checker.sv
`timescale 1ns/1ps
module dram_cmd_checker
  import dram_cmd_pkg::*;
#(
  parameter int NUM_BANKS  = 16,
  parameter int T_RCD      = 3,
  parameter int T_RAS      = 6,
  parameter int T_RP       = 3,
  parameter int REF_WINDOW = 64,
  localparam int BW        = $clog2(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  output logic          err_valid,
  output logic [3:0]    err_kind,
  output logic [BW-1:0] err_bank
);
  logic [NUM_BANKS-1:0] bank_open, rcd_met, ras_met, rp_met, act_go, pre_go;
  logic act_ok, pre_ok, ref_ok, due, pend;
  err_e cmd_err;
  op_e  op;

  always_comb begin
    op = OP_NOP;
    if (cmd_valid) begin
      case (cmd_op)
        3'd1:    op = OP_ACT;
        3'd2:    op = OP_PRE;
        3'd3:    op = OP_RD;
        3'd4:    op = OP_WR;
        3'd5:    op = OP_REF;
        default: op = OP_NOP;
      endcase
    end
  end

  always_comb begin
    cmd_err = ERR_NONE;
    act_ok  = 1'b0;
    pre_ok  = 1'b0;
    ref_ok  = 1'b0;
    case (op)
      OP_ACT: begin
        if (bank_open[cmd_bank])    cmd_err = ERR_EXTRA_ACT;
        else if (!rp_met[cmd_bank]) cmd_err = ERR_EARLY_ACT;
        else                        act_ok  = 1'b1;
      end
      OP_PRE: begin
        if (!bank_open[cmd_bank])    cmd_err = ERR_EXTRA_PRE;
        else if (!ras_met[cmd_bank]) cmd_err = ERR_EARLY_PRE;
        else                         pre_ok  = 1'b1;
      end
      OP_RD, OP_WR: begin
        if (!bank_open[cmd_bank])    cmd_err = ERR_MISSING_ACT;
        else if (!rcd_met[cmd_bank]) cmd_err = ERR_EARLY_RW;
      end
      OP_REF: begin
        if (|bank_open) cmd_err = ERR_REF_OPEN;
        else            ref_ok  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign act_go[i] = act_ok && (cmd_bank == BW'(i));
    assign pre_go[i] = pre_ok && (cmd_bank == BW'(i));
    bank_track #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_go(act_go[i]), .pre_go(pre_go[i]),
      .is_open(bank_open[i]), .rcd_met(rcd_met[i]),
      .ras_met(ras_met[i]), .rp_met(rp_met[i])
    );
  end

  refresh_timer #(.WINDOW(REF_WINDOW)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .due(due)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_kind  <= ERR_NONE;
      err_bank  <= '0;
      pend      <= 1'b0;
    end else if (cmd_err != ERR_NONE) begin
      err_valid <= 1'b1;
      err_kind  <= cmd_err;
      err_bank  <= (cmd_err == ERR_REF_OPEN) ? '0 : cmd_bank;
      pend      <= pend | due;
    end else if (due || pend) begin
      err_valid <= 1'b1;
      err_kind  <= ERR_REF_LATE;
      err_bank  <= '0;
      pend      <= 1'b0;
    end else begin
      err_valid <= 1'b0;
      err_kind  <= ERR_NONE;
      err_bank  <= '0;
    end
  end
endmodule

// File: rtl/dram_cmd_checker_sva.sv
`timescale 1ns/1ps
module dram_cmd_checker_sva #(
  parameter int NUM_BANKS = 16,
  parameter int BW        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic [BW-1:0]        cmd_bank,
  input logic                 err_valid,
  input logic [3:0]           err_kind,
  input logic [BW-1:0]        err_bank,
  input logic [NUM_BANKS-1:0] bank_open
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !err_valid);

  a_r1_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_kind != 4'd0 && err_kind <= 4'd8));

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |-> err_kind == 4'd0);

  a_r2_extra_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && bank_open[cmd_bank])
    |=> (err_valid && err_kind == 4'd1 && err_bank == $past(cmd_bank)));

  a_r4_extra_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && !bank_open[cmd_bank])
    |=> (err_valid && err_kind == 4'd3 && err_bank == $past(cmd_bank)));

  a_r6_missing_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4) && !bank_open[cmd_bank])
    |=> (err_valid && err_kind == 4'd5 && err_bank == $past(cmd_bank)));

  a_r9_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5 && (|bank_open))
    |=> (err_valid && err_kind == 4'd8 && err_bank == '0));

  a_r10_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && bank_open[cmd_bank])
    |=> $stable(bank_open));
endmodule

bind dram_cmd_checker dram_cmd_checker_sva #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .err_valid(err_valid), .err_kind(err_kind),
  .err_bank(err_bank), .bank_open(bank_open)
);

// File: tb/dram_cmd_checker_tb.sv
`timescale 1ns/1ps
module dram_cmd_checker_tb;
  localparam int RCD = 3, RAS = 5, RP = 2, WIN = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [3:0] cmd_bank = 4'd0;
  logic       err_valid;
  logic [3:0] err_kind, err_bank;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_cmd_checker #(.NUM_BANKS(16), .T_RCD(RCD), .T_RAS(RAS), .T_RP(RP),
                     .REF_WINDOW(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .err_valid(err_valid), .err_kind(err_kind),
    .err_bank(err_bank)
  );

  // One cycle: present command at a falling edge, judge the registered report at the next.
  task automatic step(input int op, input int bank, input int ek, input int eb, input string req);
    cmd_valid = (op != 0);
    cmd_op    = 3'(op);
    cmd_bank  = 4'(bank);
    @(negedge clk);
    checks++;
    if (err_valid !== (ek != 0) || (ek != 0 && (err_kind !== 4'(ek) || err_bank !== 4'(eb)))) begin
      errors++;
      $display("FAIL %s: valid=%0b kind=%0d bank=%0d expected kind=%0d bank=%0d",
               req, err_valid, err_kind, err_bank, ek, eb);
    end
  endtask

  task automatic nops(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (err_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b expected 0 in reset", err_valid);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");

    // R7 sweep of activate-to-access gap
    for (int k = 1; k <= RCD + 2; k++) begin
      step(5, 0, 0, 0, "R8");
      step(1, k, 0, 0, "R7");
      nops(k - 1, "R7");
      step((k % 2) ? 3 : 4, k, (k < RCD) ? 6 : 0, k, "R7");
      nops(RAS, "R7");
      step(2, k, 0, 0, "R5");
      nops(RP, "R3");
    end

    // R5 sweep of activate-to-precharge gap, R10 early precharge keeps bank open
    for (int k = 1; k <= RAS + 1; k++) begin
      step(5, 0, 0, 0, "R8");
      step(1, k + 4, 0, 0, "R5");
      nops(k - 1, "R5");
      step(2, k + 4, (k < RAS) ? 4 : 0, k + 4, "R5");
      if (k < RAS) begin
        nops(RAS, "R10");
        step(2, k + 4, 0, 0, "R10");
      end
      nops(RP, "R3");
    end

    // R3 sweep of precharge-to-activate gap, R10 early activate keeps bank closed
    for (int k = 1; k <= RP + 2; k++) begin
      step(5, 0, 0, 0, "R8");
      step(1, k + 10, 0, 0, "R3");
      nops(RAS - 1, "R5");
      step(2, k + 10, 0, 0, "R5");
      nops(k - 1, "R3");
      step(1, k + 10, (k < RP) ? 2 : 0, k + 10, "R3");
      if (k < RP) begin
        step(4, k + 10, 5, k + 10, "R10");
        nops(RP, "R3");
        step(1, k + 10, 0, 0, "R3");
      end
      nops(RAS, "R5");
      step(2, k + 10, 0, 0, "R5");
      nops(RP, "R3");
    end

    // R2 duplicate activate, bank stays usable
    for (int j = 0; j < 3; j++) begin
      automatic int b = (j == 0) ? 0 : (j == 1) ? 9 : 15;
      step(5, 0, 0, 0, "R8");
      step(1, b, 0, 0, "R2");
      step(1, b, 1, b, "R2");
      nops(RCD, "R2");
      step(3, b, 0, 0, "R2");
      nops(RAS, "R2");
      step(2, b, 0, 0, "R2");
      nops(RP, "R2");
    end

    // R4 and R6 on every bank
    step(5, 0, 0, 0, "R8");
    for (int b = 0; b < 16; b++) step(2, b, 3, b, "R4");
    step(5, 0, 0, 0, "R8");
    for (int b = 0; b < 16; b++) step((b % 2) ? 3 : 4, b, 5, b, "R6");

    // R8 extra refreshes are silent; unused opcodes are no-ops
    step(5, 0, 0, 0, "R8");
    step(5, 0, 0, 0, "R8");
    step(5, 0, 0, 0, "R8");
    step(6, 3, 0, 0, "R8");
    step(7, 3, 0, 0, "R8");

    // R8 overdue refresh, repeating
    step(5, 0, 0, 0, "R8");
    nops(WIN - 1, "R8");
    step(0, 0, 7, 0, "R8");
    nops(WIN - 1, "R8");
    step(0, 0, 7, 0, "R8");

    // R9 refresh with an open bank is flagged and does not restart the window
    step(5, 0, 0, 0, "R9");
    step(1, 2, 0, 0, "R9");
    step(5, 0, 8, 0, "R9");
    nops(RAS, "R9");
    step(2, 2, 0, 0, "R9");
    nops(WIN - 4 - RAS, "R9");
    step(0, 0, 7, 0, "R9");

    // R11 collision of command error and refresh deadline
    step(5, 0, 0, 0, "R11");
    nops(WIN - 1, "R11");
    step(2, 7, 3, 7, "R11");
    step(0, 0, 7, 0, "R11");
    step(5, 0, 0, 0, "R11");
    nops(2, "R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule